// File: doc/BRIEF.md
# Audio Capture Sample Packer

This block sits on the capture side of an audio subsystem, between a set of sample sources and the memory writer. It listens to one of several 32-bit sample ports, which one being chosen by a select field. From each accepted sample it takes a programmable bit slice, extends it to the width of its container with either sign or zero fill, and packs the containers into 64-bit words. Each finished word is offered on a valid/ready output together with the address it belongs at. A word counter raises a one-cycle interrupt each time a programmed number of words has been written.

The container size follows a kind code. Code 0 gives eight 8-bit lanes, code 2 gives four 16-bit lanes, and code 4 gives two 32-bit lanes. Any other code stalls the block. An optional channel alignment uses a first-of-frame marker on the sample port to restart packing at lane 0. A 0-to-1 transition on a restart control returns the address to a programmed start and clears all packing state.

The lane filler is a three-state machine. The states are `ST_HALT` (illegal kind or just out of reset), `ST_FILL` (accepting samples) and `ST_EMIT` (offering a full word). Its transitions are:
- *resume*: HALT to FILL once the kind is legal.
- *full*: FILL to EMIT when the last lane is written.
- *sent*: EMIT to FILL on `out_ready`.
- *bad kind*: any state to HALT while the kind is illegal.
- *restart*: any state to FILL on a restart edge when the kind is legal.

Top module: `cap_packer`

## Requirements
- R1: The value packed for a sample is bits `cfg_hi_bit` down to `cfg_lo_bit` of the 32-bit input, right-justified in its lane. The lane width is 8 bits for kind 0, 16 for kind 2 and 32 for kind 4.
- R2: With `cfg_sext`=1, the lane bits above the slice repeat the slice's top bit. With `cfg_sext`=0 they are zero. The result is cut to the lane width.
- R3: The first sample of a word occupies bits [W-1:0], where W is the lane width, and later samples fill upward. `out_valid` rises only after every lane is written. An offered word stays stable until `out_ready` is high.
- R4: Only bit `cfg_src_sel` of `in_ready` can be high. Valid, data and marker on the other ports have no effect on the output.
- R5: With `cfg_align`=1, a sample whose `in_first` bit is set goes into lane 0 and discards any partly filled lanes. With `cfg_align`=0, `in_first` has no effect.
- R6: `out_addr` is 0 after reset and advances by 8 after each word handshake.
- R7: A 0-to-1 transition of `cfg_restart` sets `out_addr` to `cfg_start_addr` on that clock edge. It also drops any partial or pending word and clears the word count.
- R8: In the cycle after the handshake that brings the word count to `cfg_irq_level`, `irq` is high for one cycle and the count restarts. A level of 0 never interrupts.
- R9: While `cfg_kind` is not 0, 2 or 4, `in_ready` is all zero and no word is offered. Any partial word is discarded.
- R10: During reset `in_ready`, `out_valid` and `irq` are 0 and `out_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_src_sel | input | SEL_W | Selected sample port |
| cfg_kind | input | 3 | Container kind code (0, 2, 4) |
| cfg_hi_bit | input | 5 | Top bit of the slice |
| cfg_lo_bit | input | 5 | Bottom bit of the slice |
| cfg_sext | input | 1 | 1: sign fill, 0: zero fill |
| cfg_align | input | 1 | Enable first-of-frame alignment |
| cfg_restart | input | 1 | Pointer restart control (acts on rising edge) |
| cfg_start_addr | input | ADDR_W | Address loaded on restart |
| cfg_irq_level | input | THR_W | Words per interrupt, 0 disables |
| in_valid | input | NUM_IN | Per-port sample valid |
| in_first | input | NUM_IN | Per-port first-of-frame marker |
| in_data | input | NUM_IN*32 | Per-port samples, port p at bits [32p+31:32p] |
| in_ready | output | NUM_IN | Per-port accept |
| out_valid | output | 1 | Packed word offered |
| out_ready | input | 1 | Word taken |
| out_data | output | 64 | Packed word |
| out_addr | output | ADDR_W | Byte address of the offered word |
| irq | output | 1 | Threshold pulse |

## Verification
The assertions check four things on every cycle:
- An offered word holds its data until it is taken.
- The address steps by 8 on each handshake and loads the start value on a restart edge.
- The interrupt never lasts two cycles.
- An illegal kind shuts every ready.

The lane contents need the bench's scenarios. These cover slice position, the choice of sign or zero fill, and lane order in each kind, as well as alignment discards, restart dropping a partial word, and the interrupt count. In each case a reference model predicts whole words and addresses.

// File: rtl/cap_pkg.sv
package cap_pkg;

    typedef enum logic [1:0] {
        ST_HALT = 2'd0,
        ST_FILL = 2'd1,
        ST_EMIT = 2'd2
    } fill_state_e;

    localparam logic [2:0] KIND_B8  = 3'd0;
    localparam logic [2:0] KIND_B16 = 3'd2;
    localparam logic [2:0] KIND_B32 = 3'd4;

    function automatic logic kind_legal(input logic [2:0] k);
        return (k == KIND_B8) || (k == KIND_B16) || (k == KIND_B32);
    endfunction

endpackage

// File: rtl/cap_slice.sv
module cap_slice #(
    parameter int SAMPLE_W = 32,
    localparam int POS_W = $clog2(SAMPLE_W)
) (
    input  logic [SAMPLE_W-1:0] sample,
    input  logic [POS_W-1:0]    hi_bit,
    input  logic [POS_W-1:0]    lo_bit,
    input  logic                sext,
    output logic [SAMPLE_W-1:0] ext
);
    logic [SAMPLE_W-1:0] shifted;
    logic [POS_W-1:0]    span;
    logic                fill;

    always_comb begin
        shifted = sample >> lo_bit;
        span    = hi_bit - lo_bit;
        fill    = sext & shifted[span];
        for (int i = 0; i < SAMPLE_W; i++) begin
            ext[i] = (i <= int'(span)) ? shifted[i] : fill;
        end
    end

endmodule

// File: rtl/cap_fill_fsm.sv
module cap_fill_fsm
    import cap_pkg::*;
#(
    parameter int SAMPLE_W = 32,
    parameter int WORD_W   = 64,
    localparam int MAX_LANES = WORD_W / 8,
    localparam int LIDX_W    = $clog2(MAX_LANES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2:0]          kind,
    input  logic                align,
    input  logic                restart,
    input  logic                s_valid,
    input  logic                s_first,
    input  logic [SAMPLE_W-1:0] s_ext,
    output logic                s_ready,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [WORD_W-1:0]   out_data
);
    fill_state_e         state_q, state_d;
    logic                kind_ok;
    logic [LIDX_W-1:0]   lane_q, eff_lane, lane_last;
    logic [WORD_W-1:0]   word_q, word_d;
    logic                accept, is_full, sync_hit;

    assign kind_ok  = kind_legal(kind);
    assign sync_hit = s_first && align;
    assign accept   = s_ready && s_valid;
    assign eff_lane = sync_hit ? '0 : lane_q;
    assign is_full  = accept && (eff_lane == lane_last);

    always_comb begin
        unique case (kind)
            KIND_B8:  lane_last = LIDX_W'(MAX_LANES - 1);
            KIND_B16: lane_last = LIDX_W'(WORD_W / 16 - 1);
            default:  lane_last = LIDX_W'(WORD_W / 32 - 1);
        endcase
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (!kind_ok) begin
            state_d = ST_HALT;
        end else if (restart) begin
            state_d = ST_FILL;
        end else begin
            unique case (state_q)
                ST_HALT: state_d = ST_FILL;
                ST_FILL: if (is_full) state_d = ST_EMIT;
                ST_EMIT: if (out_ready) state_d = ST_FILL;
                default: state_d = ST_HALT;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        s_ready   = 1'b0;
        out_valid = 1'b0;
        unique case (state_q)
            ST_FILL: s_ready   = kind_ok;
            ST_EMIT: out_valid = 1'b1;
            default: ;
        endcase
    end

    // lane packing
    always_comb begin
        word_d = sync_hit ? '0 : word_q;
        unique case (kind)
            KIND_B8:  word_d[int'(eff_lane) * 8  +: 8]  = s_ext[7:0];
            KIND_B16: word_d[int'(eff_lane) * 16 +: 16] = s_ext[15:0];
            default:  word_d[int'(eff_lane) * 32 +: 32] = s_ext[31:0];
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lane_q <= '0;
            word_q <= '0;
        end else if (!kind_ok || restart || state_q == ST_HALT) begin
            lane_q <= '0;
        end else if (accept) begin
            word_q <= word_d;
            lane_q <= is_full ? '0 : eff_lane + 1'b1;
        end
    end

    assign out_data = word_q;

    // R3: an offered word is held until taken
    a_r3_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !restart && kind_ok) |=> (out_valid && $stable(out_data)));

endmodule

// File: rtl/cap_ptr.sv
module cap_ptr #(
    parameter int ADDR_W     = 32,
    parameter int THR_W      = 8,
    parameter int WORD_BYTES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart_lvl,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [THR_W-1:0]  level,
    input  logic              hs,
    output logic              restart_pulse,
    output logic [ADDR_W-1:0] addr,
    output logic              irq
);
    logic             prev_q;
    logic [THR_W-1:0] cnt_q;

    assign restart_pulse = restart_lvl && !prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            addr   <= '0;
            cnt_q  <= '0;
            irq    <= 1'b0;
        end else begin
            prev_q <= restart_lvl;
            irq    <= 1'b0;
            if (restart_pulse) begin
                addr  <= start_addr;
                cnt_q <= '0;
            end else if (hs) begin
                addr <= addr + ADDR_W'(WORD_BYTES);
                if (level != '0 && cnt_q + 1'b1 == level) begin
                    irq   <= 1'b1;
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    // R6: address steps by one word per handshake
    a_r6_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (hs && !restart_pulse) |=> (addr == $past(addr) + ADDR_W'(WORD_BYTES)));

    // R7: restart edge loads the start address
    a_r7_restart_load: assert property (@(posedge clk) disable iff (!rst_n)
        restart_pulse |=> (addr == $past(start_addr) && !irq));

    // R8: interrupt is a single-cycle pulse
    a_r8_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

endmodule

// File: rtl/cap_packer.sv
module cap_packer
    import cap_pkg::*;
#(
    parameter int NUM_IN   = 8,
    parameter int SAMPLE_W = 32,
    parameter int WORD_W   = 64,
    parameter int ADDR_W   = 32,
    parameter int THR_W    = 8,
    localparam int SEL_W   = $clog2(NUM_IN),
    localparam int POS_W   = $clog2(SAMPLE_W)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [SEL_W-1:0]           cfg_src_sel,
    input  logic [2:0]                 cfg_kind,
    input  logic [POS_W-1:0]           cfg_hi_bit,
    input  logic [POS_W-1:0]           cfg_lo_bit,
    input  logic                       cfg_sext,
    input  logic                       cfg_align,
    input  logic                       cfg_restart,
    input  logic [ADDR_W-1:0]          cfg_start_addr,
    input  logic [THR_W-1:0]           cfg_irq_level,
    input  logic [NUM_IN-1:0]          in_valid,
    input  logic [NUM_IN-1:0]          in_first,
    input  logic [NUM_IN*SAMPLE_W-1:0] in_data,
    output logic [NUM_IN-1:0]          in_ready,
    output logic                       out_valid,
    input  logic                       out_ready,
    output logic [WORD_W-1:0]          out_data,
    output logic [ADDR_W-1:0]          out_addr,
    output logic                       irq
);
    logic                sel_valid, sel_first, fsm_ready, restart_pulse;
    logic [SAMPLE_W-1:0] sel_data, ext;

    assign sel_valid = in_valid[cfg_src_sel];
    assign sel_first = in_first[cfg_src_sel];
    assign sel_data  = in_data[int'(cfg_src_sel) * SAMPLE_W +: SAMPLE_W];

    for (genvar g = 0; g < NUM_IN; g++) begin : g_ready
        assign in_ready[g] = fsm_ready && (int'(cfg_src_sel) == g);
    end

    cap_slice #(.SAMPLE_W(SAMPLE_W)) u_slice (
        .sample (sel_data),
        .hi_bit (cfg_hi_bit),
        .lo_bit (cfg_lo_bit),
        .sext   (cfg_sext),
        .ext    (ext)
    );

    cap_fill_fsm #(.SAMPLE_W(SAMPLE_W), .WORD_W(WORD_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .kind      (cfg_kind),
        .align     (cfg_align),
        .restart   (restart_pulse),
        .s_valid   (sel_valid),
        .s_first   (sel_first),
        .s_ext     (ext),
        .s_ready   (fsm_ready),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data)
    );

    cap_ptr #(.ADDR_W(ADDR_W), .THR_W(THR_W), .WORD_BYTES(WORD_W / 8)) u_ptr (
        .clk           (clk),
        .rst_n         (rst_n),
        .restart_lvl   (cfg_restart),
        .start_addr    (cfg_start_addr),
        .level         (cfg_irq_level),
        .hs            (out_valid && out_ready),
        .restart_pulse (restart_pulse),
        .addr          (out_addr),
        .irq           (irq)
    );

    // R9: an illegal kind leaves every port unready
    a_r9_bad_kind_stall: assert property (@(posedge clk) disable iff (!rst_n)
        !kind_legal(cfg_kind) |=> (kind_legal(cfg_kind) || (in_ready == '0 && !out_valid)));

endmodule

// File: tb/cap_packer_tb.sv
module cap_packer_tb;
    localparam int NUM_IN = 8;

    logic        clk = 0, rst_n = 0;
    logic [2:0]  cfg_src_sel = 0, cfg_kind = 4;
    logic [4:0]  cfg_hi_bit = 31, cfg_lo_bit = 8;
    logic        cfg_sext = 1, cfg_align = 0, cfg_restart = 0;
    logic [31:0] cfg_start_addr = 0;
    logic [7:0]  cfg_irq_level = 2;
    logic [NUM_IN-1:0]    in_valid = 0, in_first = 0;
    logic [NUM_IN*32-1:0] in_data = 0;
    logic [NUM_IN-1:0]    in_ready;
    logic        out_valid, out_ready = 1, irq;
    logic [63:0] out_data;
    logic [31:0] out_addr;

    cap_packer u_dut (.*);

    always #2.5 clk = ~clk;

    typedef struct { logic [63:0] d; logic [31:0] a; } item_t;
    item_t q[$];
    int checks = 0, fails = 0;
    int irq_seen = 0, exp_irq = 0;
    int m_lane = 0, m_words = 0;
    logic [63:0] m_word = 0;
    logic [31:0] m_addr = 0;
    logic bp_en = 0;
    logic [3:0] rdy_cnt = 0;
    string cur_req = "R3";

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        rdy_cnt   <= rdy_cnt + 1;
        out_ready <= !bp_en || (rdy_cnt[1:0] != 2'd0);
    end

    // monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (irq) irq_seen++;
            if (out_valid && out_ready) begin
                if (q.size() == 0) begin
                    check({cur_req, " unexpected word"}, out_data, 64'hx);
                end else begin
                    item_t it;
                    it = q.pop_front();
                    check({cur_req, " data"}, out_data, it.d);
                    check("R6 addr", {32'd0, out_addr}, {32'd0, it.a});
                end
            end
        end
    end

    // reference model: called for each accepted sample
    task automatic model(input logic [31:0] data, input logic first);
        int lw, nl, n;
        logic signed [31:0] t;
        logic [31:0] e;
        lw = (cfg_kind == 0) ? 8 : (cfg_kind == 2) ? 16 : 32;
        nl = 64 / lw;
        if (first && cfg_align) begin m_lane = 0; m_word = 0; end
        t = data << (31 - cfg_hi_bit);
        n = 31 - int'(cfg_hi_bit) + int'(cfg_lo_bit);
        e = cfg_sext ? 32'(t >>> n) : 32'($unsigned(t) >> n);
        for (int b = 0; b < lw; b++) m_word[m_lane * lw + b] = e[b];
        m_lane++;
        if (m_lane == nl) begin
            q.push_back('{d: m_word, a: m_addr});
            m_addr += 8;
            m_words++;
            if (cfg_irq_level != 0 && m_words == int'(cfg_irq_level)) begin
                exp_irq++;
                m_words = 0;
            end
            m_lane = 0;
        end
    endtask

    task automatic send(input int p, input logic [31:0] data, input logic first);
        @(negedge clk);
        in_valid[p] = 1;
        in_first[p] = first;
        in_data[p*32 +: 32] = data;
        while (!in_ready[p]) @(negedge clk);
        @(posedge clk);
        model(data, first);
        @(negedge clk);
        in_valid[p] = 0;
        in_first[p] = 0;
    endtask

    task automatic drain();
        int n = 0;
        while (q.size() != 0 && n < 2000) begin @(negedge clk); n++; end
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
    end

    initial begin
        // R10 reset state
        repeat (2) @(negedge clk);
        check("R10 in_ready", {56'd0, in_ready}, 64'd0);
        check("R10 out_valid", {63'd0, out_valid}, 64'd0);
        check("R10 out_addr", {32'd0, out_addr}, 64'd0);
        check("R10 irq", {63'd0, irq}, 64'd0);
        rst_n = 1;
        repeat (2) @(negedge clk);

        // R1/R2: kind 4, 24-bit slice, sign fill
        cur_req = "R2";
        send(0, 32'hFFFF_8000, 0);
        send(0, 32'h1234_5678, 0);
        send(0, 32'h8000_0100, 0);
        send(0, 32'h7FFF_FF00, 0);
        drain();

        // R1/R3: kind 2, upper half, zero fill, port 3, backpressure
        cur_req = "R3";
        cfg_kind = 2; cfg_hi_bit = 31; cfg_lo_bit = 16; cfg_sext = 0; cfg_src_sel = 3;
        bp_en = 1;
        @(negedge clk);
        // R4: unselected port never ready
        check("R4 port0 ready", {63'd0, in_ready[0]}, 64'd0);
        in_valid[0] = 1; in_data[31:0] = 32'hDEAD_BEEF;
        for (int i = 0; i < 8; i++) send(3, 32'hA000_0000 + i * 32'h0101_0000, 0);
        drain();
        in_valid[0] = 0;

        // R1: kind 0, mid slice, sign fill, port 7
        cur_req = "R1";
        cfg_kind = 0; cfg_hi_bit = 15; cfg_lo_bit = 8; cfg_sext = 1; cfg_src_sel = 7;
        for (int i = 0; i < 16; i++) send(7, 32'h0000_0000 + i * 32'h0000_1300, 0);
        drain();
        bp_en = 0;

        // R2: zero fill of a 4-bit slice in 8-bit lanes
        cur_req = "R2";
        cfg_hi_bit = 11; cfg_lo_bit = 8; cfg_sext = 0;
        for (int i = 0; i < 8; i++) send(7, 32'h0000_0F00 - i * 32'h100, 0);
        drain();

        // R5: alignment discards partial lanes
        cur_req = "R5";
        cfg_kind = 2; cfg_hi_bit = 31; cfg_lo_bit = 16; cfg_sext = 1; cfg_align = 1;
        send(7, 32'h1111_0000, 0);
        send(7, 32'h2222_0000, 0);
        send(7, 32'h3333_0000, 1);
        send(7, 32'h4444_0000, 0);
        send(7, 32'h5555_0000, 0);
        send(7, 32'h6666_0000, 0);
        drain();
        // R5: marker ignored with alignment off
        cfg_align = 0;
        send(7, 32'h7777_0000, 0);
        send(7, 32'h8888_0000, 1);
        send(7, 32'h9999_0000, 0);
        send(7, 32'hAAAA_0000, 0);
        drain();

        // R7: restart drops partial and loads start address
        cur_req = "R7";
        send(7, 32'hBBBB_0000, 0);
        @(negedge clk);
        cfg_start_addr = 32'h0000_1000;
        cfg_restart = 1;
        @(negedge clk);
        cfg_restart = 0;
        check("R7 start addr", {32'd0, out_addr}, 64'h1000);
        m_lane = 0; m_addr = 32'h1000; m_words = 0;
        for (int i = 0; i < 4; i++) send(7, 32'h0100_0000 * (i + 1), 0);
        drain();

        // R9: illegal kind stalls and discards partial
        cur_req = "R9";
        send(7, 32'hCCCC_0000, 0);
        @(negedge clk);
        cfg_kind = 3;
        in_valid[7] = 1; in_data[7*32 +: 32] = 32'hEEEE_0000;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check("R9 in_ready", {56'd0, in_ready}, 64'd0);
            check("R9 out_valid", {63'd0, out_valid}, 64'd0);
        end
        in_valid[7] = 0;
        m_lane = 0;
        cfg_kind = 2;
        for (int i = 0; i < 4; i++) send(7, 32'h0F00_0000 + i * 32'h10000, 0);
        drain();

        // R8: interrupt count
        check("R8 irq count", 64'(irq_seen), 64'(exp_irq));
        check("R3 queue empty", 64'(q.size()), 64'd0);
        summary();
    end

endmodule